// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns parallel characters into frames on one serial line that rests high between frames. The host puts a character into a holding register. On the next bit-rate enable pulse, the block copies that character into its shift register. It then sends a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Each bit lasts from one enable pulse to the next. The enable pulse comes from a baud-rate generator outside the block.

Four static inputs set the frame format: 7 or 8 data bits, parity on or off, even or odd parity, and one or two stop bits. These inputs may change only while the transmitter is idle. The holding register forms a second buffer beside the shift register. The host can therefore write the next character while the current one is being sent. A character that is waiting starts on the same enable pulse that ends the previous frame's last stop bit.

Top module: `async_char_tx`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1 and `tx_end` is 1. `txd` is 1 whenever no frame is being sent.
- R2: The first `bit_en` pulse after a character is held starts a frame with one start bit at 0.
- R3: The data bits follow the start bit with bit 0 first. There are 7 bits (`wr_data[6:0]`) when `cfg_seven`=1 and 8 bits otherwise.
- R4: When `cfg_par_en`=1, one parity bit follows the data. It equals the XOR of the data bits sent, XORed with `cfg_par_odd`, so 0 gives even parity and 1 gives odd. When `cfg_par_en`=0, no parity bit is sent.
- R5: The frame ends with one stop bit at 1, or two when `cfg_two_stop`=1.
- R6: Each bit holds its level from one `bit_en` pulse until the next.
- R7: A character written while a frame is being sent starts with its start bit right after the last stop bit, with no idle bit between them.
- R8: `hold_empty` goes to 1 when the held character moves to the shift register. It goes to 0 when a write is accepted.
- R9: `tx_end` goes to 1 when the last stop bit ends while no character is held. It goes to 0 when a write is accepted.
- R10: A write while `hold_empty`=0 is ignored. That character is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit-rate enable pulse |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | 1: send a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_end | output | 1 | Transmitter idle, with nothing held |

## Verification
The assertions assume that `bit_en` is a single-cycle pulse. They also assume that the four format inputs stay fixed from the moment a character is accepted until `tx_end` returns to 1. If the format changed during a frame, the frame length and the end-of-frame check would disagree. The bench drives `bit_en` from a free-running divide-by-four counter. It changes the format only after it has seen `tx_end` high following each frame. It sweeps all sixteen format combinations with characters whose bit 7 differs from the rest, so that the 7-bit parity check is meaningful.

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int DMAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            cfg_seven,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_two_stop,
  input  logic            wr_en,
  input  logic [DMAX-1:0] wr_data,
  output logic            txd,
  output logic            hold_empty,
  output logic            tx_end
);
  localparam int FW = DMAX + 4;
  localparam int CW = $clog2(FW + 1);

  logic [DMAX-1:0] hold_q;
  logic            hold_full;
  logic [FW-1:0]   sh_q;
  logic [CW-1:0]   cnt_q;
  logic            busy_q;
  logic            end_q;

  logic [CW-1:0]   dlen, nbits;
  logic [DMAX-1:0] mask;
  logic            par_bit;
  logic [FW-1:0]   frame;
  logic            last, load, accept;

  assign dlen    = cfg_seven ? CW'(DMAX - 1) : CW'(DMAX);
  assign nbits   = dlen + CW'(2) + CW'(cfg_par_en) + CW'(cfg_two_stop);
  assign mask    = cfg_seven ? {1'b0, {(DMAX-1){1'b1}}} : {DMAX{1'b1}};
  assign par_bit = (^(hold_q & mask)) ^ cfg_par_odd;
  assign last    = busy_q && (cnt_q == nbits - CW'(1));
  assign load    = bit_en && hold_full && (!busy_q || last);
  assign accept  = wr_en && !hold_full;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int k = 0; k < DMAX; k++)
      if (CW'(k) < dlen) frame[k+1] = hold_q[k];
    if (cfg_par_en) frame[dlen + CW'(1)] = par_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '1;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      end_q     <= 1'b1;
    end else begin
      if (load) begin
        sh_q   <= frame;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (bit_en && busy_q) begin
        if (last) busy_q <= 1'b0;
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        cnt_q <= cnt_q + CW'(1);
      end

      if (load) hold_full <= 1'b0;
      else if (accept) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end

      if (accept) end_q <= 1'b0;
      else if (bit_en && last && !hold_full) end_q <= 1'b1;
    end
  end

  assign txd        = busy_q ? sh_q[0] : 1'b1;
  assign hold_empty = !hold_full;
  assign tx_end     = end_q;

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  p_bit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bit_en) |=> $stable(txd));
  p_empty_on_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_empty);
  p_end_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && last && !hold_full && !wr_en) |=> tx_end);
  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> !busy_q);
  p_ignore_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !load) |=> $stable(hold_q));
endmodule

// File: tb/async_char_tx_bench.sv
module async_char_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en;
  logic cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, hold_empty, tx_end;
  logic [1:0] div_q = '0;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) div_q <= div_q + 2'd1;
  assign bit_en = (div_q == 2'd3);

  async_char_tx u_async_char_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .hold_empty(hold_empty), .tx_end(tx_end));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_char(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check(hold_empty == 1'b0, "R8 empty cleared by write", int'(hold_empty), 0);
    check(tx_end == 1'b0, "R9 end cleared by write", int'(tx_end), 0);
  endtask

  task automatic wait_start();
    for (int i = 0; i < 200; i++) begin
      if (txd == 1'b0) return;
      @(negedge clk);
    end
    check(1'b0, "R2 start bit never seen", int'(txd), 0);
  endtask

  task automatic rx_frame(input logic [7:0] d);
    logic exp_bits [12];
    string tags [12];
    int n, dl;
    logic p;
    dl = cfg_seven ? 7 : 8;
    n = 0;
    exp_bits[n] = 1'b0; tags[n] = "R2 start"; n++;
    p = cfg_par_odd;
    for (int k = 0; k < dl; k++) begin
      exp_bits[n] = d[k]; tags[n] = "R3 data"; n++;
      p = p ^ d[k];
    end
    if (cfg_par_en) begin exp_bits[n] = p; tags[n] = "R4 parity"; n++; end
    exp_bits[n] = 1'b1; tags[n] = "R5 stop"; n++;
    if (cfg_two_stop) begin exp_bits[n] = 1'b1; tags[n] = "R5 stop2"; n++; end
    for (int i = 0; i < n; i++) begin
      check(txd == exp_bits[i], tags[i], int'(txd), int'(exp_bits[i]));
      repeat (3) @(negedge clk);
      check(txd == exp_bits[i], "R6 bit held", int'(txd), int'(exp_bits[i]));
      if (i < n - 1) @(negedge clk);
    end
  endtask

  task automatic single(input logic [3:0] cfg, input logic [7:0] d);
    {cfg_seven, cfg_par_en, cfg_par_odd, cfg_two_stop} = cfg;
    write_char(d);
    wait_start();
    rx_frame(d);
    @(negedge clk);
    check(txd == 1'b1, "R1 idle after frame", int'(txd), 1);
    check(tx_end == 1'b1, "R9 end after last stop", int'(tx_end), 1);
    check(hold_empty == 1'b1, "R8 empty after move", int'(hold_empty), 1);
  endtask

  task automatic back_to_back(input logic [3:0] cfg, input logic [7:0] a,
                              input logic [7:0] b, input logic [7:0] c);
    {cfg_seven, cfg_par_en, cfg_par_odd, cfg_two_stop} = cfg;
    write_char(a);
    for (int i = 0; i < 20 && !hold_empty; i++) @(negedge clk);
    check(hold_empty == 1'b1, "R8 empty on move", int'(hold_empty), 1);
    fork
      begin
        write_char(b);
        write_char(c);
        check(hold_empty == 1'b0, "R10 still full", int'(hold_empty), 0);
      end
      rx_frame(a);
    join
    @(negedge clk);
    check(txd == 1'b0, "R7 no gap between frames", int'(txd), 0);
    rx_frame(b);
    @(negedge clk);
    check(tx_end == 1'b1, "R9 end after second frame", int'(tx_end), 1);
    for (int i = 0; i < 48; i++) begin
      if (txd != 1'b1) begin
        check(1'b0, "R10 ignored char sent", int'(txd), 1);
        break;
      end
      @(negedge clk);
    end
    check(txd == 1'b1 && tx_end == 1'b1, "R10 line stays idle", int'(txd), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81, 8'h7E};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset line", int'(txd), 1);
    check(hold_empty == 1'b1, "R1 reset empty", int'(hold_empty), 1);
    check(tx_end == 1'b1, "R1 reset end", int'(tx_end), 1);
    for (int c = 0; c < 16; c++)
      for (int j = 0; j < 6; j++)
        single(4'(c), pats[j]);
    back_to_back(4'b1111, 8'hC3, 8'h96, 8'h00);
    back_to_back(4'b0000, 8'h01, 8'h80, 8'h55);
    back_to_back(4'b0110, 8'h3C, 8'hE7, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule